// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is an SPI slave (mode 0) that gives a host access to a bank of 8-bit configuration registers. While the select line is held low, the bytes on the serial line alternate between an address byte and a value byte. A host can therefore write several registers in one select period. During every value slot the block shifts out the present content of the addressed register.

Writes do not reach the bank while the burst is in progress. Each completed write pair goes into a small staging buffer. When select rises, the buffer is presented to the register bank as one group, with a one-cycle commit strobe, so that all the new values take effect together.

The serial inputs are brought into the system clock domain through two-flop synchronizers. All logic then runs on the system clock. The controller has three states:
- `ST_IDLE`: select is high.
- `ST_ADDR`: the address slot is being shifted in.
- `ST_VALUE`: the value slot is being shifted in while read data is shifted out.

Transitions:
- IDLE→ADDR when select falls.
- ADDR→VALUE on the eighth rising clock edge of the address byte.
- VALUE→ADDR on the eighth rising clock edge of the value byte.
- Any state→IDLE when select rises.

Top module: `cfg_spi_port`

## Requirements
- R1: While select is low, bytes alternate between address and value, starting with an address. Several write pairs can be sent in one select period and all of them are applied.
- R2: Written values are held in staging and change nothing in the bank until select rises. After select rises, `commit_stb` pulses high for exactly one cycle, with `commit_mask` marking the valid slots. The staging is then empty.
- R3: During a value slot, `spi_miso` carries the current content of the register named in the preceding address byte, bit 7 first.
- R4: `spi_miso_oe` is high only during a value slot. It is low while select is high and during address slots. An external pad driver releases MISO to high impedance when `spi_miso_oe` is low.
- R5: `spi_mosi` is sampled on the rising edge of `spi_sck`, and `spi_miso` changes only after a falling edge of `spi_sck`. Bytes travel MSB first.
- R6: In the address byte, bit 7 selects the access: 0 means write and 1 means read. Bits 4:0 give the register address. Bits 6:5 are ignored. A read pair stages nothing.
- R7: If one burst writes the same address twice, the later value is the one committed.
- R8: Up to 8 distinct addresses can be staged in one burst. A further distinct address replaces the oldest staged entry, so that entry's write is lost.
- R9: If select rises in the middle of a byte, the partial byte is discarded. Pairs completed earlier in the same burst are still committed.
- R10: After reset, `spi_miso_oe` and `commit_stb` are low and `commit_mask` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_mosi | input | 1 | Serial data from host |
| spi_csn | input | 1 | Active-low select |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Output enable for MISO |
| rd_addr | output | 5 | Address of register being read |
| rd_data | input | 8 | Content of the register at `rd_addr` |
| commit_stb | output | 1 | One-cycle pulse applying staged writes |
| commit_mask | output | 8 | Valid staging slots during the pulse |
| commit_addr | output | 40 | Slot i address at bits [5i+4:5i] |
| commit_data | output | 64 | Slot i value at bits [8i+7:8i] |

## Verification
The hardest situation to reach is a staging buffer that has filled and wrapped. It needs nine distinct write pairs inside one select period before the oldest entry is replaced. The bench sends such a burst and checks that only the first address keeps its old value.

The bench also drives these cases:
- a burst that rewrites one address, to check that the later value wins;
- a burst cut off four bits into an address byte, to check that earlier pairs still commit;
- a read pair, to check that the bank is left unchanged.

// File: rtl/cfg_spi_pkg.sv
package cfg_spi_pkg;
    localparam int BYTE_W = 8;
    localparam int REG_AW = 5;
    localparam int STAGE_DEPTH = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_VALUE
    } spi_state_e;
endpackage

// File: rtl/cfg_spi_sync.sv
module cfg_spi_sync #(
    parameter int W = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    for (genvar g = 0; g < W; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta[g] <= RST_VAL[g];
                q[g]    <= RST_VAL[g];
            end else begin
                meta[g] <= d[g];
                q[g]    <= meta[g];
            end
        end
    end
endmodule

// File: rtl/cfg_spi_fsm.sv
module cfg_spi_fsm
    import cfg_spi_pkg::*;
#(
    parameter int DW = BYTE_W,
    parameter int AW = REG_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_act,
    input  logic          sck_rise,
    input  logic          sck_fall,
    input  logic          mosi,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          miso,
    output logic          miso_oe,
    output logic          pair_valid,
    output logic [AW-1:0] pair_addr,
    output logic [DW-1:0] pair_data
);
    localparam int CW = $clog2(DW);
    localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

    spi_state_e    state, state_nx;
    logic [CW-1:0] bitcnt;
    logic [DW-1:0] in_sr, out_sr;
    logic [DW-1:0] byte_now;
    logic          wr_q;
    logic          byte_done;

    assign byte_now  = {in_sr[DW-2:0], mosi};
    assign byte_done = sck_rise && (bitcnt == LAST_BIT);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (cs_act) state_nx = ST_ADDR;
            ST_ADDR:  if (!cs_act) state_nx = ST_IDLE;
                      else if (byte_done) state_nx = ST_VALUE;
            ST_VALUE: if (!cs_act) state_nx = ST_IDLE;
                      else if (byte_done) state_nx = ST_ADDR;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt     <= '0;
            in_sr      <= '0;
            out_sr     <= '0;
            miso       <= 1'b0;
            wr_q       <= 1'b0;
            rd_addr    <= '0;
            pair_valid <= 1'b0;
            pair_data  <= '0;
        end else begin
            pair_valid <= 1'b0;
            if (!cs_act || state == ST_IDLE) begin
                bitcnt <= '0;
            end else begin
                if (sck_rise) begin
                    in_sr  <= byte_now;
                    bitcnt <= bitcnt + 1'b1;
                    if (byte_done && state == ST_ADDR) begin
                        rd_addr <= byte_now[AW-1:0];
                        wr_q    <= ~byte_now[DW-1];
                    end
                    if (byte_done && state == ST_VALUE) begin
                        pair_valid <= wr_q;
                        pair_data  <= byte_now;
                    end
                end
                if (sck_fall && state == ST_VALUE) begin
                    if (bitcnt == '0) begin
                        miso   <= rd_data[DW-1];
                        out_sr <= {rd_data[DW-2:0], 1'b0};
                    end else begin
                        miso   <= out_sr[DW-1];
                        out_sr <= {out_sr[DW-2:0], 1'b0};
                    end
                end
            end
        end
    end

    assign miso_oe   = (state == ST_VALUE);
    assign pair_addr = rd_addr;

    AST_NO_OE_AFTER_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> !miso_oe); // R4
    AST_PAIR_FROM_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |-> $past(state == ST_VALUE)); // R1
    AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_fall |=> $stable(miso)); // R5
    AST_PARTIAL_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IDLE |-> bitcnt == '0); // R9
endmodule

// File: rtl/cfg_spi_stage.sv
module cfg_spi_stage
    import cfg_spi_pkg::*;
#(
    parameter int DW = BYTE_W,
    parameter int AW = REG_AW,
    parameter int DEPTH = STAGE_DEPTH
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pair_valid,
    input  logic [AW-1:0]       pair_addr,
    input  logic [DW-1:0]       pair_data,
    input  logic                end_burst,
    output logic                commit_stb,
    output logic [DEPTH-1:0]    commit_mask,
    output logic [DEPTH*AW-1:0] commit_addr,
    output logic [DEPTH*DW-1:0] commit_data
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST_SLOT = PW'(DEPTH - 1);

    logic [DEPTH-1:0] valid;
    logic [AW-1:0]    addr_r [DEPTH];
    logic [DW-1:0]    data_r [DEPTH];
    logic [PW-1:0]    wp;
    logic [DEPTH-1:0] hit;
    logic [PW-1:0]    hit_idx;

    always_comb begin
        hit     = '0;
        hit_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            hit[i] = valid[i] && (addr_r[i] == pair_addr);
            if (hit[i]) hit_idx = PW'(i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid      <= '0;
            wp         <= '0;
            commit_stb <= 1'b0;
            for (int i = 0; i < DEPTH; i++) begin
                addr_r[i] <= '0;
                data_r[i] <= '0;
            end
        end else begin
            commit_stb <= end_burst && (|valid);
            if (commit_stb) begin
                valid <= '0;
                wp    <= '0;
            end else if (pair_valid) begin
                if (|hit) begin
                    data_r[hit_idx] <= pair_data;
                end else begin
                    valid[wp]  <= 1'b1;
                    addr_r[wp] <= pair_addr;
                    data_r[wp] <= pair_data;
                    wp         <= (wp == LAST_SLOT) ? '0 : wp + 1'b1;
                end
            end
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_out
        assign commit_addr[g*AW +: AW] = addr_r[g];
        assign commit_data[g*DW +: DW] = data_r[g];
    end
    assign commit_mask = commit_stb ? valid : '0;

    AST_COMMIT_AFTER_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        commit_stb |-> $past(end_burst)); // R2
    AST_EMPTY_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        commit_stb |=> valid == '0); // R2
    AST_NO_DUP_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit)); // R7
endmodule

// File: rtl/cfg_spi_port.sv
module cfg_spi_port
    import cfg_spi_pkg::*;
#(
    parameter int DW = BYTE_W,
    parameter int AW = REG_AW,
    parameter int DEPTH = STAGE_DEPTH
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                spi_sck,
    input  logic                spi_mosi,
    input  logic                spi_csn,
    output logic                spi_miso,
    output logic                spi_miso_oe,
    output logic [AW-1:0]       rd_addr,
    input  logic [DW-1:0]       rd_data,
    output logic                commit_stb,
    output logic [DEPTH-1:0]    commit_mask,
    output logic [DEPTH*AW-1:0] commit_addr,
    output logic [DEPTH*DW-1:0] commit_data
);
    logic [2:0]    sync_q;
    logic          csn_s, sck_s, mosi_s;
    logic          csn_q, sck_q;
    logic          pair_valid;
    logic [AW-1:0] pair_addr;
    logic [DW-1:0] pair_data;

    cfg_spi_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({spi_csn, spi_sck, spi_mosi}), .q(sync_q)
    );
    assign {csn_s, sck_s, mosi_s} = sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csn_q <= 1'b1;
            sck_q <= 1'b0;
        end else begin
            csn_q <= csn_s;
            sck_q <= sck_s;
        end
    end

    cfg_spi_fsm #(.DW(DW), .AW(AW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cs_act(~csn_s),
        .sck_rise(sck_s & ~sck_q),
        .sck_fall(~sck_s & sck_q),
        .mosi(mosi_s),
        .rd_data(rd_data), .rd_addr(rd_addr),
        .miso(spi_miso), .miso_oe(spi_miso_oe),
        .pair_valid(pair_valid), .pair_addr(pair_addr), .pair_data(pair_data)
    );

    cfg_spi_stage #(.DW(DW), .AW(AW), .DEPTH(DEPTH)) u_stage (
        .clk(clk), .rst_n(rst_n),
        .pair_valid(pair_valid), .pair_addr(pair_addr), .pair_data(pair_data),
        .end_burst(csn_s & ~csn_q),
        .commit_stb(commit_stb), .commit_mask(commit_mask),
        .commit_addr(commit_addr), .commit_data(commit_data)
    );

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !commit_stb && !spi_miso_oe); // R10
endmodule

// File: tb/cfg_spi_port_bench.sv
module cfg_spi_port_bench;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0, mosi = 1'b0, csn = 1'b1;
    logic        miso, miso_oe, cstb;
    logic [4:0]  rd_addr;
    logic [7:0]  rd_data;
    logic [7:0]  cmask;
    logic [39:0] caddr;
    logic [63:0] cdata;
    logic [7:0]  bank [32];
    logic [7:0]  model [32];
    int          checks = 0, errors = 0, commits = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    assign rd_data = bank[rd_addr];

    cfg_spi_port u_cfg_spi_port (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_mosi(mosi), .spi_csn(csn),
        .spi_miso(miso), .spi_miso_oe(miso_oe), .rd_addr(rd_addr), .rd_data(rd_data),
        .commit_stb(cstb), .commit_mask(cmask), .commit_addr(caddr), .commit_data(cdata)
    );

    always @(negedge clk) begin
        if (cstb) begin
            commits++;
            for (int i = 0; i < 8; i++)
                if (cmask[i]) bank[caddr[i*5 +: 5]] = cdata[i*8 +: 8];
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] tx, input int nbits, input bit value_slot,
                        output logic [7:0] rx);
        for (int i = 7; i > 7 - nbits; i--) begin
            mosi = tx[i];
            wclk(HALF);
            rx[i] = miso;
            check(miso_oe == value_slot, value_slot ? "R4 oe in value" : "R4 oe in addr",
                  miso_oe, value_slot);
            sck = 1'b1;
            wclk(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic sel;
        csn = 1'b0;
        wclk(6);
    endtask

    task automatic desel;
        wclk(6);
        csn = 1'b1;
        wclk(12);
    endtask

    task automatic pair(input logic [7:0] a, input logic [7:0] d, output logic [7:0] rx);
        logic [7:0] dummy;
        xfer(a, 8, 1'b0, dummy);
        xfer(d, 8, 1'b1, rx);
    endtask

    task automatic cmp_bank(input string tag);
        for (int i = 0; i < 32; i++)
            if (bank[i] !== model[i]) check(0, tag, bank[i], model[i]);
        check(1, tag, 0, 0);
    endtask

    // addr byte, value, register actually targeted
    localparam logic [23:0] VEC [6] = '{
        24'h03_A5_03, 24'h1F_3C_1F, 24'h63_77_03,
        24'h00_FF_00, 24'h12_01_12, 24'h43_80_03
    };

    initial begin
        logic [7:0] rx;
        int c0;
        for (int i = 0; i < 32; i++) begin
            bank[i]  = 8'(i * 7 + 8'h1D);
            model[i] = bank[i];
        end
        wclk(5);
        // R10 reset state
        check(miso_oe == 0, "R10 oe", miso_oe, 0);
        check(cstb == 0, "R10 commit_stb", cstb, 0);
        check(cmask == 0, "R10 commit_mask", cmask, 0);
        rst_n = 1'b1;
        wclk(5);

        // table: single-pair bursts (R1 R3 R5 R6)
        for (int v = 0; v < 6; v++) begin
            sel();
            pair(VEC[v][23:16], VEC[v][15:8], rx);
            check(rx == model[VEC[v][4:0]], "R3 readout", rx, model[VEC[v][4:0]]);
            desel();
            model[VEC[v][4:0]] = VEC[v][15:8];
            cmp_bank("R6 addr bits / R1 write");
        end

        // multi-pair burst, staged until deselect (R1 R2)
        c0 = commits;
        sel();
        pair(8'h05, 8'h11, rx);
        pair(8'h06, 8'h22, rx);
        pair(8'h07, 8'h33, rx);
        wclk(10);
        check(commits == c0, "R2 no commit before deselect", commits - c0, 0);
        check(bank[5] == model[5], "R2 bank held during burst", bank[5], model[5]);
        desel();
        check(commits == c0 + 1, "R2 single commit pulse", commits - c0, 1);
        model[5] = 8'h11; model[6] = 8'h22; model[7] = 8'h33;
        cmp_bank("R1 multi-pair");

        // same address twice (R7)
        sel();
        pair(8'h08, 8'h44, rx);
        pair(8'h08, 8'h55, rx);
        check(rx == model[8], "R3 readout before commit", rx, model[8]);
        desel();
        model[8] = 8'h55;
        cmp_bank("R7 later wins");

        // read pair stages nothing (R6)
        c0 = commits;
        sel();
        pair(8'h86, 8'hEE, rx);
        check(rx == model[6], "R6 read data", rx, model[6]);
        desel();
        check(commits == c0, "R6 read no commit", commits - c0, 0);
        cmp_bank("R6 read leaves bank");

        // nine distinct writes: oldest lost (R8)
        sel();
        for (int k = 0; k < 9; k++) pair(8'(10 + k), 8'(8'hC0 + k), rx);
        desel();
        for (int k = 1; k < 9; k++) model[10 + k] = 8'(8'hC0 + k);
        cmp_bank("R8 overflow drops oldest");

        // cut mid byte (R9)
        sel();
        pair(8'h14, 8'h9A, rx);
        xfer(8'h15, 4, 1'b0, rx);
        desel();
        model[20] = 8'h9A;
        cmp_bank("R9 partial byte discarded");
        check(miso_oe == 0, "R4 oe idle", miso_oe, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule